// File: doc/BRIEF.md
# Transmit Pad and FCS Inserter

This stage sits in the transmit byte path between the frame source and the serializer. Bytes arrive with a valid/ready handshake, marked with start-of-frame and end-of-frame flags. The stage passes the data through unchanged. When it is told to, it extends the frame with zero bytes up to a minimum length and then appends a 32-bit frame check sequence. The check sequence is computed over everything emitted before it, the pad included.

Three controls select what is appended: a global check-disable input, a per-frame no-check flag, and an auto-pad enable. All three are taken together with the start-of-frame byte and hold for the whole frame. With auto-pad on, a check sequence is always appended, whatever the other two say. With auto-pad off, no pad is ever inserted, and the check sequence is appended only when neither suppression input is set. While pad or check bytes are going out, the input side is held off. Output backpressure freezes all internal progress.

Top module: `tx_pad_fcs`

## Requirements
- R1: Input bytes leave in order with the same value and start flag, and each input handshake is one output transfer (in_ready_o equals out_ready_i while data is passing).
- R2: With auto-pad on and N < MIN_LEN (default 60) data bytes, exactly MIN_LEN-N bytes of value 0x00 follow the last data byte, and only then the check sequence.
- R3: With auto-pad on and N >= MIN_LEN data bytes, no pad byte is inserted and the check sequence directly follows the data.
- R4: The check sequence is 4 bytes: CRC-32 (polynomial 0x04C11DB7, processed reflected as 0xEDB88320, register preset to all ones, result complemented) over all data and pad bytes, sent least significant byte first. The end flag is on its last byte only.
- R5: With auto-pad off, the check sequence is appended only if fcs_dis_i and in_nofcs_i are both 0; otherwise the end flag is on the last data byte and nothing follows.
- R6: With auto-pad on, the check sequence is appended even when fcs_dis_i or in_nofcs_i is 1.
- R7: pad_en_i, fcs_dis_i and in_nofcs_i are sampled with the start-of-frame byte; changes on them during later bytes of the same frame have no effect on its output.
- R8: in_ready_o is 0 while pad or check bytes are offered. Under out_ready_i = 0 the offered byte and its end flag stay unchanged, and no byte is lost or repeated.
- R9: During and right after reset, with no input offered, out_valid_o is 0 and in_ready_o follows out_ready_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input byte offered |
| in_ready_o | output | 1 | Input byte accepted this cycle when valid |
| in_data_i | input | 8 | Input byte |
| in_sof_i | input | 1 | First byte of a frame |
| in_eof_i | input | 1 | Last data byte of a frame |
| in_nofcs_i | input | 1 | Per-frame request to omit the check sequence, sampled with the first byte |
| fcs_dis_i | input | 1 | Global check-sequence disable, sampled with the first byte |
| pad_en_i | input | 1 | Auto-pad enable, sampled with the first byte |
| out_valid_o | output | 1 | Output byte offered |
| out_ready_i | input | 1 | Downstream accepts the output byte |
| out_data_o | output | 8 | Output byte |
| out_sof_o | output | 1 | First byte of an output frame |
| out_eof_o | output | 1 | Last byte of an output frame |

## Verification
The assertions check several properties on every cycle. Inserted bytes hold steady, and the CRC and length state freeze, while the output stalls. Pad is only produced for frames that sampled auto-pad on. A padded frame never reaches its check sequence short of the minimum length, and always ends inside a check sequence. The state returns to pass-through after every frame end. The exact pad count, the CRC value and byte order, and the suppression and override decisions need the bench's scenarios, which cover one-byte, just-short, exact and long frames, every control combination, controls toggled mid-frame, and random stalls on both sides.

// File: rtl/tx_pad_fcs_pkg.sv
package tx_pad_fcs_pkg;
  localparam int BYTE_W    = 8;
  localparam int CRC_W     = 32;
  localparam int FCS_BYTES = CRC_W / BYTE_W;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_PRESET    = '1;

  typedef enum logic [1:0] {
    ST_DATA = 2'd0,
    ST_PAD  = 2'd1,
    ST_FCS  = 2'd2
  } tx_state_e;

  // one byte through the reflected LFSR, lsb first
  function automatic logic [CRC_W-1:0] crc_step_byte(input logic [CRC_W-1:0] crc,
                                                     input logic [BYTE_W-1:0] data);
    logic [CRC_W-1:0] c;
    c = crc ^ {{(CRC_W-BYTE_W){1'b0}}, data};
    for (int b = 0; b < BYTE_W; b++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/tpf_crc_unit.sv
module tpf_crc_unit
  import tx_pad_fcs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              restart_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_base;
  logic [CRC_W-1:0] crc_d;

  assign crc_base = restart_i ? CRC_PRESET : crc_q;
  assign crc_d    = crc_step_byte(crc_base, data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= CRC_PRESET;
    else if (step_i) crc_q <= crc_d;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/tpf_len_counter.sv
module tpf_len_counter #(
  parameter int MIN_LEN = 60,
  parameter int CNT_W   = $clog2(MIN_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             reach_o
);
  localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_LEN);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_next;

  // count of bytes including the one being stepped now, saturating
  always_comb begin
    if (restart_i)            cnt_next = ONE;
    else if (cnt_q >= MIN_CNT) cnt_next = MIN_CNT;
    else                      cnt_next = cnt_q + ONE;
  end

  assign reach_o = (cnt_next >= MIN_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_next;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tpf_fcs_mux.sv
module tpf_fcs_mux
  import tx_pad_fcs_pkg::*;
#(
  parameter int IDX_W = $clog2(FCS_BYTES)
) (
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [BYTE_W-1:0] byte_o
);
  logic [BYTE_W-1:0] fcs_bytes [FCS_BYTES];

  for (genvar g = 0; g < FCS_BYTES; g++) begin : g_lane
    assign fcs_bytes[g] = ~crc_i[g*BYTE_W +: BYTE_W];
  end

  assign byte_o = fcs_bytes[idx_i];
endmodule

// File: rtl/tx_pad_fcs.sv
module tx_pad_fcs
  import tx_pad_fcs_pkg::*;
#(
  parameter int MIN_LEN = 60
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [BYTE_W-1:0] in_data_i,
  input  logic              in_sof_i,
  input  logic              in_eof_i,
  input  logic              in_nofcs_i,
  input  logic              fcs_dis_i,
  input  logic              pad_en_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [BYTE_W-1:0] out_data_o,
  output logic              out_sof_o,
  output logic              out_eof_o
);
  localparam int CNT_W = $clog2(MIN_LEN + 1);
  localparam int IDX_W = $clog2(FCS_BYTES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FCS_BYTES - 1);

  tx_state_e         state_q, state_d;
  logic              pad_q, fcs_q;
  logic [IDX_W-1:0]  idx_q;
  logic              first, pad_eff, fcs_eff, need_pad;
  logic              out_fire, step;
  logic              reach;
  logic [CNT_W-1:0]  cnt_w;
  logic [CRC_W-1:0]  crc_w;
  logic [BYTE_W-1:0] fcs_byte;

  assign first   = (state_q == ST_DATA) && in_sof_i;
  assign pad_eff = first ? pad_en_i : pad_q;
  assign fcs_eff = first ? (pad_en_i | ~(fcs_dis_i | in_nofcs_i)) : fcs_q;
  assign need_pad = pad_eff & ~reach;

  assign out_fire = out_valid_o && out_ready_i;
  assign step     = out_fire && (state_q != ST_FCS);

  tpf_crc_unit u_crc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .restart_i (first),
    .data_i    (out_data_o),
    .crc_o     (crc_w)
  );

  tpf_len_counter #(
    .MIN_LEN (MIN_LEN),
    .CNT_W   (CNT_W)
  ) u_len (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .restart_i (first),
    .cnt_o     (cnt_w),
    .reach_o   (reach)
  );

  tpf_fcs_mux #(
    .IDX_W (IDX_W)
  ) u_mux (
    .crc_i  (crc_w),
    .idx_i  (idx_q),
    .byte_o (fcs_byte)
  );

  always_comb begin
    in_ready_o  = 1'b0;
    out_valid_o = 1'b0;
    out_data_o  = '0;
    out_sof_o   = 1'b0;
    out_eof_o   = 1'b0;
    unique case (state_q)
      ST_DATA: begin
        in_ready_o  = out_ready_i;
        out_valid_o = in_valid_i;
        out_data_o  = in_data_i;
        out_sof_o   = in_sof_i;
        out_eof_o   = in_eof_i & ~need_pad & ~fcs_eff;
      end
      ST_PAD: begin
        out_valid_o = 1'b1;
      end
      ST_FCS: begin
        out_valid_o = 1'b1;
        out_data_o  = fcs_byte;
        out_eof_o   = (idx_q == IDX_LAST);
      end
      default: ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_DATA: if (out_fire && in_eof_i) begin
        if (need_pad)     state_d = ST_PAD;
        else if (fcs_eff) state_d = ST_FCS;
      end
      ST_PAD:  if (out_fire && reach) state_d = ST_FCS;
      ST_FCS:  if (out_fire && (idx_q == IDX_LAST)) state_d = ST_DATA;
      default: state_d = ST_DATA;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_DATA;
      pad_q   <= 1'b0;
      fcs_q   <= 1'b0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (out_fire && first) begin
        pad_q <= pad_eff;
        fcs_q <= fcs_eff;
      end
      if (out_fire && (state_q == ST_FCS))
        idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + IDX_W'(1);
    end
  end

  assert_pad_only_when_enabled_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PAD) |-> pad_q);

  assert_min_len_before_fcs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FCS && pad_q) |-> (cnt_w >= CNT_W'(MIN_LEN)));

  assert_eof_returns_to_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_fire && out_eof_o) |=> (state_q == ST_DATA));

  assert_padded_frame_ends_in_fcs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_fire && out_eof_o && pad_eff) |-> (state_q == ST_FCS));

  assert_hold_under_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_DATA && out_valid_o && !out_ready_i)
      |=> (out_valid_o && $stable(out_data_o) && $stable(out_eof_o)));

  assert_state_frozen_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> ($stable(crc_w) && $stable(cnt_w)));
endmodule

// File: tb/tb_tx_pad_fcs.sv
module tb_tx_pad_fcs;
  localparam int MIN_LEN = 60;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       in_valid, in_ready_o, in_sof, in_eof, in_nofcs, fcs_dis, pad_en;
  logic [7:0] in_data;
  logic       out_valid_o, out_ready, out_sof_o, out_eof_o;
  logic [7:0] out_data_o;

  always #5 clk = ~clk;

  tx_pad_fcs #(.MIN_LEN(MIN_LEN)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid), .in_ready_o(in_ready_o), .in_data_i(in_data),
    .in_sof_i(in_sof), .in_eof_i(in_eof), .in_nofcs_i(in_nofcs),
    .fcs_dis_i(fcs_dis), .pad_en_i(pad_en),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready), .out_data_o(out_data_o),
    .out_sof_o(out_sof_o), .out_eof_o(out_eof_o)
  );

  typedef struct {
    logic [7:0] d;
    logic       sof;
    logic       eof;
    bit         gen;
    int         req;
  } exp_t;

  exp_t expq[$];
  int   n_chk = 0, n_bad = 0;
  int   rdy_mode = 0;

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [7:0] q[$]);
    logic [31:0] c = 32'hFFFFFFFF;
    foreach (q[i]) begin
      for (int b = 0; b < 8; b++) begin
        if (c[0] ^ q[i][b]) c = (c >> 1) ^ 32'hEDB88320;
        else                c = c >> 1;
      end
    end
    return ~c;
  endfunction

  // reference model: whole expected output frame, queued before driving
  task automatic model_frame(input logic [7:0] q[$], input bit pad, input bit dis,
                             input bit nof, input bit scr);
    logic [7:0] full[$];
    logic [31:0] crc;
    bit fcs = pad || !(dis || nof);
    int n = q.size();
    exp_t e;
    full = q;
    if (pad) while (full.size() < MIN_LEN) full.push_back(8'h00);
    for (int i = 0; i < full.size(); i++) begin
      e.d = full[i]; e.sof = (i == 0); e.eof = 1'b0; e.gen = (i >= n);
      if (scr)         e.req = 7;  // R7
      else if (i >= n) e.req = 2;  // R2 pad bytes
      else if (pad && n >= MIN_LEN) e.req = 3;  // R3
      else if (!pad)   e.req = 5;  // R5
      else             e.req = 1;  // R1
      e.eof = !fcs && (i == full.size() - 1);
      expq.push_back(e);
    end
    if (fcs) begin
      crc = ref_crc(full);
      for (int k = 0; k < 4; k++) begin
        e.d = crc[8*k +: 8]; e.sof = 1'b0; e.eof = (k == 3); e.gen = 1'b1;
        e.req = scr ? 7 : ((pad && (dis || nof)) ? 6 : 4);  // R4 / R6
        expq.push_back(e);
      end
    end
  endtask

  task automatic send(input logic [7:0] q[$], input bit pad, input bit dis,
                      input bit nof, input bit scr, input bit gaps);
    bit acc;
    model_frame(q, pad, dis, nof, scr);
    for (int i = 0; i < q.size(); i++) begin
      if (gaps) repeat ($urandom % 2) begin
        in_valid = 1'b0;
        @(posedge clk); #1;
      end
      in_valid = 1'b1;
      in_data  = q[i];
      in_sof   = (i == 0);
      in_eof   = (i == q.size() - 1);
      if (i == 0 || !scr) begin
        pad_en = pad; fcs_dis = dis; in_nofcs = nof;
      end else begin
        pad_en = 1'($urandom); fcs_dis = 1'($urandom); in_nofcs = 1'($urandom);
      end
      do begin
        @(negedge clk); acc = in_ready_o;
        @(posedge clk); #1;
      end while (!acc);
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic send_n(input int n, input int seed, input bit pad, input bit dis,
                        input bit nof, input bit scr);
    logic [7:0] q[$];
    for (int i = 0; i < n; i++) q.push_back(8'((i * 37 + seed * 11 + 5) & 255));
    send(q, pad, dis, nof, scr, 1'b1);
  endtask

  always @(posedge clk) begin
    #1;
    if (rdy_mode == 0) out_ready = 1'b1;
    else               out_ready = ($urandom % 3) != 0;
  end

  // monitor: compared every cycle at mid-period
  bit         prev_stall = 1'b0;
  logic [7:0] prev_d;
  logic       prev_e;
  exp_t       hd;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (prev_stall)  // R8 hold under stall
        chk(out_valid_o && out_data_o == prev_d && out_eof_o == prev_e, 8,
            "stall hold {v,eof,data}", {23'd0, out_valid_o, out_eof_o, out_data_o},
            {23'd0, 1'b1, prev_e, prev_d});
      if (out_valid_o && expq.size() > 0 && expq[0].gen)  // R8 input held off
        chk(!in_ready_o, 8, "in_ready during insert", 32'(in_ready_o), 32'd0);
      if (out_valid_o && out_ready) begin
        if (expq.size() == 0) begin
          chk(1'b0, 1, "unexpected output byte", 32'(out_data_o), 32'd0);
        end else begin
          hd = expq.pop_front();
          chk(out_data_o == hd.d && out_sof_o == hd.sof && out_eof_o == hd.eof, hd.req,
              "{sof,eof,data}", {22'd0, out_sof_o, out_eof_o, out_data_o},
              {22'd0, hd.sof, hd.eof, hd.d});
        end
      end
      prev_stall = out_valid_o && !out_ready;
      prev_d = out_data_o;
      prev_e = out_eof_o;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] q[$];
    rst_ni = 1'b0; in_valid = 1'b0; in_data = '0; in_sof = 1'b0; in_eof = 1'b0;
    in_nofcs = 1'b0; fcs_dis = 1'b0; pad_en = 1'b0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid_o == 1'b0, 9, "out_valid in reset", 32'(out_valid_o), 32'd0);  // R9
    @(posedge clk); #1 rst_ni = 1'b1;
    @(negedge clk);
    chk(out_valid_o == 1'b0, 9, "out_valid after reset", 32'(out_valid_o), 32'd0);
    chk(in_ready_o == out_ready, 9, "in_ready after reset", 32'(in_ready_o), 32'(out_ready));
    @(posedge clk); #1;

    // R4 anchor: known CRC-32 of ASCII "123456789"
    q = {8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    chk(ref_crc(q) == 32'hCBF43926, 4, "model crc anchor", ref_crc(q), 32'hCBF43926);

    rdy_mode = 0;
    send_n(1, 1, 1, 0, 0, 0);        // R2 one-byte frame, 59 pad
    send_n(59, 2, 1, 0, 0, 0);       // R2 one pad byte
    send_n(60, 3, 1, 0, 0, 0);       // R3 exact
    send_n(61, 4, 1, 0, 0, 0);       // R3 long
    send(q, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);  // R4 byte order

    rdy_mode = 1;
    send_n(10, 5, 0, 0, 0, 0);       // R5 fcs appended
    send_n(10, 6, 0, 1, 0, 0);       // R5 global disable
    send_n(12, 7, 0, 0, 1, 0);       // R5 per-frame no fcs
    send_n(1, 8, 0, 1, 1, 0);        // R5 single byte pass
    send_n(20, 9, 1, 1, 1, 0);       // R6 override both
    send_n(25, 10, 1, 1, 0, 0);      // R6 override global
    send_n(30, 11, 1, 0, 0, 1);      // R7 controls toggled mid-frame
    send_n(15, 12, 0, 0, 0, 1);      // R7
    send_n(14, 13, 0, 1, 0, 1);      // R7
    send_n(45, 14, 1, 0, 0, 0);      // R8 random stalls with pad
    send_n(70, 15, 0, 0, 0, 0);      // R1 long pass-through

    for (int t = 0; t < 2000 && expq.size() > 0; t++) @(posedge clk);
    #1;
    chk(expq.size() == 0, 1, "bytes left undelivered", 32'(expq.size()), 32'd0);  // R1
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule